// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Generator

This block maps each red, green and blue sample of a pixel stream through one programmable transfer curve. The curve is made of sixteen connected straight pieces. A host loads sixteen 8-bit levels, and each level is the output at the far end of one piece. Between two levels the output is interpolated linearly. Because the levels may sit anywhere in 0..255, the same hardware serves for gamma shaping, contrast stretching, offset and range limiting. All three colour lanes share the curve, and each lane is computed on its own.

Host writes go into a shadow copy of the levels. The copy in use changes only when a frame-boundary strobe arrives, so no frame is ever drawn with a mix of two curves. Pixels arrive with a valid strobe. The result leaves a fixed two clock cycles later, carrying the same strobe.

Top module: `gamma_pwl`

## Requirements
- R1: `pix_out_vld` equals `pix_in_vld` delayed by exactly two clock cycles, and `pix_out` carries the mapped value of the pixel accepted two cycles earlier.
- R2: The upper 4 bits of an 8-bit sample select the segment k, and the lower 4 bits are the fraction f. Segment k runs from the level of point k-1 to the level of point k. For k = 0 the start level is 0.
- R3: The output is start + floor(((end - start) * f + 8) / 16), computed with signed arithmetic and clamped to 0..255.
- R4: The 24-bit pixel packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The shared curve is applied to each lane independently.
- R5: A write (`cfg_we`, with point index `cfg_idx` and level `cfg_level`) changes the curve in use only after the next `frame_sync` pulse. Until then the output follows the previous curve.
- R6: A write issued in the same cycle as `frame_sync` is not part of that switch. It takes effect at the following `frame_sync`.
- R7: After reset, point k holds min(16*(k+1), 255) in both copies. This makes the curve the identity for inputs below 240, and it maps 255 to 254.
- R8: On a non-decreasing segment the output lies between the segment's start and end levels. A fraction of 0 yields exactly the start level.
- R9: The block accepts any levels, including a segment whose end lies below its start. Such a segment is interpolated downward with the same rounding rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for one curve point |
| cfg_idx | input | 4 | Index of the point written |
| cfg_level | input | 8 | Level written to that point |
| frame_sync | input | 1 | Frame-boundary pulse that moves the shadow levels into use |
| pix_in_vld | input | 1 | Input pixel valid |
| pix_in | input | 24 | Input pixel, R in 23:16, G in 15:8, B in 7:0 |
| pix_out_vld | output | 1 | Output pixel valid, two cycles after input |
| pix_out | output | 24 | Mapped pixel, same packing as input |

## Verification
The hardest case to reach from the ports is the collision between a level write and the frame strobe in the same cycle. Here the old shadow value must be copied and the new value must wait a whole frame. The bench drives `cfg_we` and `frame_sync` from the same negative edge, sends a pixel that falls in the segment touched by the write, and sends the same pixel again after a second strobe. A falling segment with an odd difference is also built on purpose, so that the negative rounding path is exercised.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int PIX_W  = 8;
  localparam int SEG_W  = 4;
  localparam int FRAC_W = PIX_W - SEG_W;
  localparam int NPTS   = 1 << SEG_W;
  localparam int NCH    = 3;
  localparam int ACC_W  = PIX_W + FRAC_W + 3;
  localparam int HALF   = 1 << (FRAC_W - 1);
  localparam int MAXV   = (1 << PIX_W) - 1;

  typedef logic signed [ACC_W-1:0] acc_t;

  // Level held by point k after reset: (k+1) * 2^FRAC_W, saturated.
  function automatic logic [PIX_W-1:0] reset_level(input int k);
    int v;
    v = (k + 1) << FRAC_W;
    if (v > MAXV) v = MAXV;
    return v[PIX_W-1:0];
  endfunction

  // Linear interpolation between lo and hi by fraction f / 2^FRAC_W,
  // rounded half-up and clamped to the pixel range.
  function automatic logic [PIX_W-1:0] pwl_interp(input logic [PIX_W-1:0] lo,
                                                  input logic [PIX_W-1:0] hi,
                                                  input logic [FRAC_W-1:0] f);
    acc_t d, p, s;
    d = acc_t'(hi) - acc_t'(lo);
    p = d * acc_t'(f);
    p = (p + acc_t'(HALF)) >>> FRAC_W;
    s = acc_t'(lo) + p;
    if (s < 0) return '0;
    if (s > acc_t'(MAXV)) return '1;
    return s[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/gamma_bank.sv
module gamma_bank #(
  parameter int NPTS  = gamma_pkg::NPTS,
  parameter int PIX_W = gamma_pkg::PIX_W,
  localparam int AW   = $clog2(NPTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [AW-1:0]              cfg_idx,
  input  logic [PIX_W-1:0]           cfg_level,
  input  logic                       frame_sync,
  output logic [NPTS-1:0][PIX_W-1:0] live
);
  logic [NPTS-1:0][PIX_W-1:0] shadow;
  logic [NPTS-1:0]            hit;

  for (genvar k = 0; k < NPTS; k++) begin : g_pt
    assign hit[k] = cfg_we && (cfg_idx == AW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[k] <= gamma_pkg::reset_level(k);
        live[k]   <= gamma_pkg::reset_level(k);
      end else begin
        if (hit[k])     shadow[k] <= cfg_level;
        if (frame_sync) live[k]   <= shadow[k];
      end
    end
  end

  // R5: the curve in use changes only on a frame strobe
  assert_live_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(live));

  // R6: the strobe copies the shadow as it stood before any same-cycle write
  assert_switch_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> live == $past(shadow));

  // R5: a write lands in the shadow copy
  assert_shadow_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> shadow[$past(cfg_idx)] == $past(cfg_level));

  assert_one_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/gamma_lane.sv
module gamma_lane #(
  parameter int NPTS  = gamma_pkg::NPTS,
  parameter int PIX_W = gamma_pkg::PIX_W,
  parameter int SEG_W = gamma_pkg::SEG_W,
  localparam int FRAC_W = PIX_W - SEG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PIX_W-1:0]           x,
  input  logic [NPTS-1:0][PIX_W-1:0] pts,
  output logic [PIX_W-1:0]           y
);
  logic [SEG_W-1:0]  seg, seg_prev;
  logic [FRAC_W-1:0] frac;
  logic [PIX_W-1:0]  seg_lo, seg_hi;

  // stage-1 registers: segment end levels and fraction
  logic [PIX_W-1:0]  s1_lo, s1_hi;
  logic [FRAC_W-1:0] s1_frac;

  assign seg      = x[PIX_W-1 -: SEG_W];
  assign frac     = x[FRAC_W-1:0];
  assign seg_prev = seg - SEG_W'(1);

  always_comb begin
    seg_hi = pts[seg];
    seg_lo = (seg == '0) ? '0 : pts[seg_prev];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_lo   <= '0;
      s1_hi   <= '0;
      s1_frac <= '0;
      y       <= '0;
    end else begin
      s1_lo   <= seg_lo;
      s1_hi   <= seg_hi;
      s1_frac <= frac;
      y       <= gamma_pkg::pwl_interp(s1_lo, s1_hi, s1_frac);
    end
  end

  // R8: a rising or flat segment keeps the output inside its end levels
  assert_in_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_lo <= s1_hi) |=> (y >= $past(s1_lo)) && (y <= $past(s1_hi)));

  // R9: a falling segment keeps the output inside its end levels too
  assert_in_span_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_lo > s1_hi) |=> (y <= $past(s1_lo)) && (y >= $past(s1_hi)));

  // R8: zero fraction returns the start level exactly
  assert_frac_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_frac == '0) |=> y == $past(s1_lo));
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl #(
  parameter int PIX_W = gamma_pkg::PIX_W,
  parameter int SEG_W = gamma_pkg::SEG_W,
  parameter int NCH   = gamma_pkg::NCH,
  localparam int NPTS = 1 << SEG_W,
  localparam int BUS_W = PIX_W * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PIX_W-1:0] cfg_level,
  input  logic             frame_sync,
  input  logic             pix_in_vld,
  input  logic [BUS_W-1:0] pix_in,
  output logic             pix_out_vld,
  output logic [BUS_W-1:0] pix_out
);
  logic [NPTS-1:0][PIX_W-1:0] live_pts;
  logic                       vld_s1;

  gamma_bank #(.NPTS(NPTS), .PIX_W(PIX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_level  (cfg_level),
    .frame_sync (frame_sync),
    .live       (live_pts)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    gamma_lane #(.NPTS(NPTS), .PIX_W(PIX_W), .SEG_W(SEG_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .x     (pix_in[c*PIX_W +: PIX_W]),
      .pts   (live_pts),
      .y     (pix_out[c*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s1      <= 1'b0;
      pix_out_vld <= 1'b0;
    end else begin
      vld_s1      <= pix_in_vld;
      pix_out_vld <= vld_s1;
    end
  end

  // R1: valid travels through two register stages
  assert_vld_stage1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_vld |=> vld_s1);
  assert_vld_stage2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out_vld == $past(vld_s1));
endmodule

// File: tb/sim_gamma_pwl.sv
module sim_gamma_pwl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_level = '0;
  logic        frame_sync = 1'b0;
  logic        pix_in_vld = 1'b0;
  logic [23:0] pix_in = '0;
  logic        pix_out_vld;
  logic [23:0] pix_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int shd[16];
  int act[16];

  always #4 clk = ~clk;

  gamma_pwl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_level(cfg_level), .frame_sync(frame_sync), .pix_in_vld(pix_in_vld),
    .pix_in(pix_in), .pix_out_vld(pix_out_vld), .pix_out(pix_out)
  );

  // Reference curve, computed with real arithmetic.
  function automatic int model(input int v);
    int s, f, lo, hi, r;
    s  = v / 16;
    f  = v % 16;
    lo = (s == 0) ? 0 : act[s-1];
    hi = act[s];
    r  = lo + int'($floor(real'((hi - lo) * f) / 16.0 + 0.5));
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send_px(input string req, input int r, input int g, input int b);
    int er, eg, eb;
    er = model(r); eg = model(g); eb = model(b);
    @(negedge clk);
    pix_in_vld = 1'b1;
    pix_in = {r[7:0], g[7:0], b[7:0]};
    @(negedge clk);
    pix_in_vld = 1'b0;
    pix_in = 24'h0;
    chk({req, " R1 valid not early"}, int'(pix_out_vld), 0);
    @(negedge clk);
    chk({req, " R1 valid at two cycles"}, int'(pix_out_vld), 1);
    chk({req, " red"},   int'(pix_out[23:16]), er);
    chk({req, " green"}, int'(pix_out[15:8]),  eg);
    chk({req, " blue"},  int'(pix_out[7:0]),   eb);
  endtask

  task automatic wr(input int k, input int lvl, input bit with_sync);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = k[3:0]; cfg_level = lvl[7:0];
    frame_sync = with_sync;
    if (with_sync) act = shd;
    shd[k] = lvl;
    @(negedge clk);
    cfg_we = 1'b0; frame_sync = 1'b0;
  endtask

  task automatic sync();
    @(negedge clk);
    frame_sync = 1'b1;
    act = shd;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 valid low after reset", int'(pix_out_vld), 0);
    send_px("R7 identity", 8'h12, 8'h34, 8'hEF);
    chk("R7 identity red literal", int'(pix_out[23:16]), 8'h12);
    send_px("R7 top code", 255, 240, 0);
    chk("R7 255 maps to 254", int'(pix_out[23:16]), 254);
  endtask

  task automatic t_deferred();
    wr(3, 100, 0);
    wr(2, 20, 0);
    send_px("R5 before strobe", 8'h38, 8'h28, 8'h3F);
    sync();
    send_px("R5 after strobe R2 R3", 8'h38, 8'h28, 8'h3F);
    chk("R3 seg3 f8 literal", int'(pix_out[23:16]), 60);
  endtask

  task automatic t_collide();
    wr(5, 200, 1);
    send_px("R6 same-cycle write held", 8'h57, 8'h5F, 8'h50);
    sync();
    send_px("R6 applied next strobe", 8'h57, 8'h5F, 8'h50);
  endtask

  task automatic t_falling();
    wr(6, 250, 0);
    wr(7, 9, 0);
    sync();
    send_px("R9 falling segment", 8'h71, 8'h7F, 8'h79);
    send_px("R8 zero fraction", 8'h70, 8'h00, 8'h60);
    chk("R8 frac0 start level", int'(pix_out[23:16]), 250);
  endtask

  task automatic t_lanes();
    wr(0, 255, 0);
    wr(15, 0, 0);
    sync();
    send_px("R4 lanes independent", 8'h08, 8'hF8, 8'h95);
    send_px("R2 segment 0 starts at zero", 8'h01, 8'h0F, 8'h00);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      shd[k] = ((k + 1) * 16 > 255) ? 255 : (k + 1) * 16;
      act[k] = shd[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_deferred();
    t_collide();
    t_falling();
    t_lanes();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule